// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment choice and an offset into a 32-bit linear address and reports when the offset falls outside the segment's limit. It holds six segment slots. Slot 0 serves instruction fetches, slot 1 serves the stack, and slots 2 to 5 serve data. Each slot keeps four things: a 16-bit segment value, a 32-bit base, a 32-bit limit and a set of attribute bits. The slots are loaded through a write port that takes effect only while a privilege strobe is high.

The kind of access picks the slot implicitly. A fetch uses the code slot, and its offset comes from the instruction-pointer input. A stack access uses the stack slot. A data access uses the first data slot unless an override names one of the four data slots. A mode input chooses between real and protected translation.

- In real mode the base is the slot's segment value shifted left by four, and the limit is fixed at 64 KB.
- In protected mode the base and limit come from the slot's descriptor, so a segment can cover up to 4 GB.

The result is registered and appears one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, out_valid, out_fault, out_addr and out_attr are zero. Every slot holds segment value 0, base 0, limit 0x0000FFFF and attribute 0.
- R2: When req_kind is 0 (fetch), slot 0 is used and the offset is taken from ip_in. off_in and the override inputs have no effect.
- R3: When req_kind is 1 (stack), slot 1 is used with off_in. The override inputs have no effect.
- R4: When req_kind is 2 or 3 (data) and ovr_en is 0, slot 2 is used with off_in. When ovr_en is 1, slot 2 + ovr_seg is used (ovr_seg 0..3 selects slots 2..5).
- R5: When req_prot is 0 (real mode), out_addr = ({16'b0, segment value} << 4) + offset modulo 2^32. out_fault is 1 exactly when the offset is greater than 0x0000FFFF.
- R6: When req_prot is 1 (protected mode), out_addr = base + offset modulo 2^32. out_fault is 1 exactly when the offset is greater than the slot's limit.
- R7: out_valid equals req_valid of the previous cycle. out_addr, out_fault and out_attr reflect the request of the previous cycle. out_fault is 0 whenever out_valid is 0.
- R8: A write loads wr_sel, wr_base, wr_limit and wr_attr into slot wr_slot at a clock edge only when wr_en and wr_priv are both 1 and wr_slot is below 6. A request in the following cycle sees the new contents. All other writes leave every slot unchanged.
- R9: out_attr is the attribute field of the slot the request used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 or 3 data |
| req_prot | input | 1 | 0 real mode, 1 protected mode |
| ovr_en | input | 1 | Use ovr_seg for a data access |
| ovr_seg | input | 2 | Data slot choice, slot 2 + value |
| ip_in | input | 32 | Instruction pointer, offset for fetches |
| off_in | input | 32 | Offset for stack and data accesses |
| wr_en | input | 1 | Slot write request |
| wr_priv | input | 1 | Privilege strobe qualifying a write |
| wr_slot | input | 3 | Slot to load, 0..5 |
| wr_sel | input | 16 | Segment value to load |
| wr_base | input | 32 | Descriptor base to load |
| wr_limit | input | 32 | Descriptor limit to load |
| wr_attr | input | 4 | Attribute bits to load |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_addr | output | 32 | Linear address |
| out_fault | output | 1 | Offset beyond limit |
| out_attr | output | 4 | Attributes of the slot used |

## Verification
The bench sweeps every access kind, both modes, both override states and every override value. It probes offsets at 0, 0xFFFF, 0x10000, each slot's limit, that limit plus one, and 0xFFFFFFFF.

- An off-by-one limit comparison shows up as a fault that appears or vanishes at exactly the limit.
- Using the protected limit in real mode, or the reverse, shows up at the 0x10000 probe.
- A base placed near the top of the address space exposes a sum that is not wrapped to 32 bits.
- Distinct attributes and bases in each slot expose a wrong default slot, and the same is true for an override that leaks into a fetch or stack access.
- Writes without the privilege strobe, and writes to slots 6 and 7, are followed by reads of every slot, so a write that should have been dropped is caught.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEL_W      = 16;
  localparam int ATTR_W     = 4;
  localparam int NUM_SEG    = 6;
  localparam int SLOT_W     = $clog2(NUM_SEG + 1);
  localparam int FIRST_DATA = 2;
  localparam int NUM_DATA   = NUM_SEG - FIRST_DATA;
  localparam int OVR_W      = $clog2(NUM_DATA);
  localparam int REAL_SHIFT = 4;
  localparam int PAD_W      = ADDR_W - SEL_W - REAL_SHIFT;
  localparam logic [ADDR_W-1:0] REAL_LIMIT = {{(ADDR_W-SEL_W){1'b0}}, {SEL_W{1'b1}}};

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_DATA2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ATTR_W-1:0] attr;
  } seg_desc_t;

  function automatic logic [ADDR_W-1:0] real_base(input logic [SEL_W-1:0] sel);
    return {{PAD_W{1'b0}}, sel, {REAL_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic beyond(input logic [ADDR_W-1:0] off,
                                  input logic [ADDR_W-1:0] lim);
    return off > lim;
  endfunction
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_priv,
  input  logic [SLOT_W-1:0] wr_slot,
  input  seg_desc_t         wr_desc,
  input  logic [SLOT_W-1:0] rd_idx,
  output seg_desc_t         rd_desc
);
  seg_desc_t slot_q [NUM_SEG];
  logic      wr_accept;

  assign wr_accept = wr_en & wr_priv & (wr_slot < SLOT_W'(NUM_SEG));

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    logic hit;
    assign hit = wr_accept & (wr_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g].sel   <= '0;
        slot_q[g].base  <= '0;
        slot_q[g].limit <= REAL_LIMIT;
        slot_q[g].attr  <= '0;
      end else if (hit) begin
        slot_q[g] <= wr_desc;
      end
    end

    // R8
    unpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_priv) |=> $stable(slot_q[g]));
  end

  always_comb begin
    rd_desc = '0;
    if (rd_idx < SLOT_W'(NUM_SEG)) rd_desc = slot_q[rd_idx];
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kind,
  input  logic              ovr_en,
  input  logic [OVR_W-1:0]  ovr_seg,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              use_ip
);
  acc_kind_e k;
  assign k = acc_kind_e'(kind);

  always_comb begin
    use_ip = 1'b0;
    unique case (k)
      ACC_FETCH: begin
        slot_idx = '0;
        use_ip   = 1'b1;
      end
      ACC_STACK: slot_idx = SLOT_W'(1);
      default: begin
        slot_idx = SLOT_W'(FIRST_DATA);
        if (ovr_en) slot_idx = SLOT_W'(FIRST_DATA) + SLOT_W'(ovr_seg);
      end
    endcase
  end

  // R2
  fetch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd0) |-> (slot_idx == '0 && use_ip));
  // R3
  stack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd1) |-> (slot_idx == SLOT_W'(1) && !use_ip));
  // R4
  data_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind[1]) |-> (slot_idx >= SLOT_W'(FIRST_DATA) && slot_idx < SLOT_W'(NUM_SEG) && !use_ip));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic              prot,
  input  seg_desc_t         desc,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              over
);
  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] lim_eff;

  assign base_eff = prot ? desc.base  : real_base(desc.sel);
  assign lim_eff  = prot ? desc.limit : REAL_LIMIT;
  assign lin_addr = wrap_add(base_eff, offset);
  assign over     = beyond(offset, lim_eff);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic        req_prot,
  input  logic        ovr_en,
  input  logic [1:0]  ovr_seg,
  input  logic [31:0] ip_in,
  input  logic [31:0] off_in,
  input  logic        wr_en,
  input  logic        wr_priv,
  input  logic [2:0]  wr_slot,
  input  logic [15:0] wr_sel,
  input  logic [31:0] wr_base,
  input  logic [31:0] wr_limit,
  input  logic [3:0]  wr_attr,
  output logic        out_valid,
  output logic [31:0] out_addr,
  output logic        out_fault,
  output logic [3:0]  out_attr
);
  logic [SLOT_W-1:0] slot_idx;
  logic              use_ip;
  seg_desc_t         wr_desc;
  seg_desc_t         rd_desc;
  logic [ADDR_W-1:0] off_sel;
  logic [ADDR_W-1:0] lin_addr;
  logic              over;

  assign wr_desc = '{sel: wr_sel, base: wr_base, limit: wr_limit, attr: wr_attr};

  seg_select u_sel (
    .clk(clk), .rst_n(rst_n), .kind(req_kind), .ovr_en(ovr_en),
    .ovr_seg(ovr_seg), .slot_idx(slot_idx), .use_ip(use_ip)
  );

  seg_desc_file u_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv),
    .wr_slot(wr_slot), .wr_desc(wr_desc), .rd_idx(slot_idx), .rd_desc(rd_desc)
  );

  assign off_sel = use_ip ? ip_in : off_in;

  seg_xlate u_xl (
    .prot(req_prot), .desc(rd_desc), .offset(off_sel),
    .lin_addr(lin_addr), .over(over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_fault <= 1'b0;
      out_attr  <= '0;
    end else begin
      out_valid <= req_valid;
      out_fault <= req_valid & over;
      if (req_valid) begin
        out_addr <= lin_addr;
        out_attr <= rd_desc.attr;
      end
    end
  end

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R7
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R7
  fault_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_valid);
  // R5
  real_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_prot && off_sel > 32'h0000_FFFF) |=> out_fault);
  // R6
  prot_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_prot && off_sel <= rd_desc.limit) |=> !out_fault);
endmodule

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        req_prot = 1'b0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [31:0] ip_in = '0;
  logic [31:0] off_in = '0;
  logic        wr_en = 1'b0;
  logic        wr_priv = 1'b0;
  logic [2:0]  wr_slot = '0;
  logic [15:0] wr_sel = '0;
  logic [31:0] wr_base = '0;
  logic [31:0] wr_limit = '0;
  logic [3:0]  wr_attr = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_fault;
  logic [3:0]  out_attr;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [15:0] m_sel   [6];
  logic [31:0] m_base  [6];
  logic [31:0] m_limit [6];
  logic [3:0]  m_attr  [6];

  always #2.5 clk = ~clk;

  seg_addr_gen u0 (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_slot(input logic priv, input logic [2:0] s, input logic [15:0] sv,
                            input logic [31:0] b, input logic [31:0] l, input logic [3:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_priv = priv; wr_slot = s;
    wr_sel = sv; wr_base = b; wr_limit = l; wr_attr = a;
    @(negedge clk);
    wr_en = 1'b0; wr_priv = 1'b0;
    if (priv && s < 3'd6) begin
      m_sel[s] = sv; m_base[s] = b; m_limit[s] = l; m_attr[s] = a;
    end
  endtask

  // Drives one request at a falling edge; result is sampled at the next falling edge.
  task automatic request(input logic [1:0] k, input logic prot, input logic oe,
                         input logic [1:0] os, input logic [31:0] o);
    req_valid = 1'b1; req_kind = k; req_prot = prot; ovr_en = oe; ovr_seg = os;
    if (k == 2'd0) begin ip_in = o; off_in = ~o; end
    else begin off_in = o; ip_in = ~o; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int exp_slot(input logic [1:0] k, input logic oe, input logic [1:0] os);
    if (k == 2'd0) return 0;
    if (k == 2'd1) return 1;
    return oe ? 2 + int'(os) : 2;
  endfunction

  task automatic verify(input string req, input string sreq, input int s,
                        input logic prot, input logic [31:0] o);
    logic [31:0] eb;
    logic        ef;
    eb = prot ? m_base[s] : ({16'h0, m_sel[s]} << 4);
    ef = prot ? (o > m_limit[s]) : (o > 32'h0000_FFFF);
    check("R7", "valid", {31'b0, out_valid}, 32'd1);
    check(req, "addr", out_addr, eb + o);
    check(req, "fault", {31'b0, out_fault}, {31'b0, ef});
    check(sreq, "attr", {28'b0, out_attr}, {28'b0, m_attr[s]});
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] offs [6];
    for (int i = 0; i < 6; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_limit[i] = 32'h0000_FFFF; m_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    check("R1", "valid", {31'b0, out_valid}, 32'd0);
    check("R1", "fault", {31'b0, out_fault}, 32'd0);
    check("R1", "addr", out_addr, 32'd0);
    check("R1", "attr", {28'b0, out_attr}, 32'd0);
    // R1 reset slot contents: base 0, limit 0xFFFF
    request(2'd2, 1'b1, 1'b1, 2'd3, 32'h0000_1234);
    check("R1", "addr", out_addr, 32'h0000_1234);
    check("R1", "fault", {31'b0, out_fault}, 32'd0);
    request(2'd1, 1'b1, 1'b0, 2'd0, 32'h0001_0000);
    check("R1", "fault", {31'b0, out_fault}, 32'd1);
    check("R1", "attr", {28'b0, out_attr}, 32'd0);

    // R8 privileged loads, distinct per slot
    write_slot(1'b1, 3'd0, 16'h0123, 32'h0010_0000, 32'h000F_FFFF, 4'h8);
    write_slot(1'b1, 3'd1, 16'h1F00, 32'h0200_0040, 32'h0000_FFFF, 4'h9);
    write_slot(1'b1, 3'd2, 16'hFFFF, 32'h0300_0000, 32'hFFFF_FFFF, 4'hA);
    write_slot(1'b1, 3'd3, 16'h8001, 32'h8000_0000, 32'h0000_0FFF, 4'hB);
    write_slot(1'b1, 3'd4, 16'h0042, 32'h0000_0001, 32'h0001_0000, 4'hC);
    write_slot(1'b1, 3'd5, 16'hABCD, 32'hFFFF_F000, 32'h0000_0000, 4'hD);

    // R2 R3 R4 R5 R6 sweep
    @(negedge clk);
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++)
        for (int oe = 0; oe < 2; oe++)
          for (int os = 0; os < 4; os++) begin
            int s;
            s = exp_slot(2'(k), 1'(oe), 2'(os));
            offs[0] = 32'h0; offs[1] = 32'h0000_FFFF; offs[2] = 32'h0001_0000;
            offs[3] = m_limit[s]; offs[4] = m_limit[s] + 32'd1; offs[5] = 32'hFFFF_FFFF;
            for (int j = 0; j < 6; j++) begin
              request(2'(k), 1'(p), 1'(oe), 2'(os), offs[j]);
              verify(p == 0 ? "R5" : "R6",
                     k == 0 ? "R2" : (k == 1 ? "R3" : "R4 R9"), s, 1'(p), offs[j]);
            end
          end

    // R7 idle cycle: no valid, no fault
    @(negedge clk);
    check("R7", "valid", {31'b0, out_valid}, 32'd0);
    check("R7", "fault", {31'b0, out_fault}, 32'd0);

    // R8 unprivileged write and out-of-range slots are dropped
    write_slot(1'b0, 3'd2, 16'h5555, 32'h1111_1111, 32'h0, 4'h1);
    write_slot(1'b1, 3'd6, 16'h6666, 32'h2222_2222, 32'h0, 4'h2);
    write_slot(1'b1, 3'd7, 16'h7777, 32'h3333_3333, 32'h0, 4'h3);
    for (int s = 0; s < 6; s++) begin
      request(s == 0 ? 2'd0 : (s == 1 ? 2'd1 : 2'd2), 1'b1, s >= 2, 2'(s - 2), 32'h10);
      check("R8", "addr", out_addr, m_base[s] + 32'h10);
      check("R8", "attr", {28'b0, out_attr}, {28'b0, m_attr[s]});
      request(s == 0 ? 2'd0 : (s == 1 ? 2'd1 : 2'd3), 1'b0, s >= 2, 2'(s - 2), 32'h10);
      check("R8", "real addr", out_addr, ({16'h0, m_sel[s]} << 4) + 32'h10);
    end

    // R8 new contents visible on the next request
    write_slot(1'b1, 3'd4, 16'h0F0F, 32'h4000_0000, 32'h0000_0010, 4'h6);
    request(2'd2, 1'b1, 1'b1, 2'd2, 32'h11);
    check("R8", "addr", out_addr, 32'h4000_0011);
    check("R8", "fault", {31'b0, out_fault}, 32'd1);
    check("R9", "attr", {28'b0, out_attr}, 32'h6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule